// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a two-wire serial bus engine and a byte-wide storage array of 4096 locations. The array is split into 128 pages of 32 bytes. During a write transaction the bus engine first loads a 12-bit address and then strobes in data bytes. Each byte goes into a 32-slot page buffer at the slot named by the low five address bits. The block also keeps a valid mask of the slots that were loaded. When the bus engine reports a stop, the block copies the loaded slots into the array through a simple synchronous write port. It then waits out a programmable self-timed cycle and holds `busy` high for the whole commit. While `busy` is high, every bus-side input is ignored.

The block owns the current-address counter. Write loading advances only the byte-in-page field, so the counter wraps inside the page. Read advances move through the whole array and wrap from FFFh to 000h. A write-protect pin is sampled at the stop that starts a commit. When it was high, no location in the top quarter of the array (C00h to FFFh) is written. The timed cycle still runs.

The controller has three states. ST_COLLECT is the idle and loading state. It moves to ST_PROGRAM on a stop when at least one slot is loaded. ST_PROGRAM walks slots 0 to 31, one per cycle, and after slot 31 it moves to ST_SETTLE. ST_SETTLE counts `WR_CYCLES` clocks and then returns to ST_COLLECT.

Top module: `page_commit`

## Requirements
- R1: After reset, `cur_addr` is 000h, `busy` is 0 and `mem_we` is 0.
- R2: An `addr_load` while not busy sets `cur_addr` to `addr_in` on the next cycle and discards every byte loaded since the last load. Bits 11..5 of an address are the page and bits 4..0 the slot. Input precedence is `stop` over `addr_load` over `byte_stb` over `rd_inc`.
- R3: Each accepted `byte_stb` stores `byte_data` in slot `cur_addr[4:0]` and increments only `cur_addr[4:0]`. The page bits 11..5 never change, so slot 31 is followed by slot 0 of the same page.
- R4: Each accepted `rd_inc` increments the whole 12-bit `cur_addr`, so FFFh is followed by 000h.
- R5: A stop with at least one loaded slot raises `busy` in the next cycle. `busy` stays high for exactly 32 + `WR_CYCLES` cycles.
- R6: During a commit, `mem_we` pulses once for each loaded slot, in ascending slot order. Each pulse carries `mem_addr` = {page, slot} and the last byte loaded into that slot. Slots not loaded are not written.
- R7: The value of `wp` at the accepted stop decides protection. When it was 1, no write reaches an address whose bits 11..10 are 11. When it was 0, every page is written.
- R8: A stop with no loaded slot starts no commit. `busy` stays 0 and no write occurs.
- R9: While `busy` is high, `byte_stb`, `addr_load`, `rd_inc` and `stop` have no effect. `cur_addr` is unchanged and no extra data is written.
- R10: Loading more than 32 bytes in one transaction overwrites the earlier bytes in the same slots. The counter keeps wrapping within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | One-cycle strobe: a received data byte is valid |
| byte_data | input | 8 | Received data byte |
| addr_load | input | 1 | One-cycle strobe: load `addr_in` into the address counter |
| addr_in | input | 12 | Address to load |
| stop | input | 1 | One-cycle strobe: the bus transaction has ended |
| wp | input | 1 | Write-protect pin for the top quarter of the array |
| rd_inc | input | 1 | One-cycle strobe: a byte was read, advance the address |
| busy | output | 1 | High during the whole commit and timed cycle |
| cur_addr | output | 12 | Current-address counter |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 12 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A stale valid mask or a wrong slot index shows up on the array port during the next commit, within 32 cycles of the stop. It appears as a write to an extra, missing or misordered address, or with the wrong byte. A counter that wraps across pages, or that moves while busy, shows on `cur_addr` one cycle after the faulty strobe. A timer or state error shows as a `busy` window of the wrong length, or as `busy` rising on a stop with nothing loaded. Protection taken from the wrong moment shows as a write into the top quarter.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_PROGRAM = 2'd1,
        ST_SETTLE  = 2'd2
    } pgc_state_t;
endpackage

// File: rtl/pgc_addr_ctr.sv
module pgc_addr_ctr #(
    parameter int ADDR_W = 12,
    parameter int OFS_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_slot,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] cur
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (inc_slot) begin
            cur[OFS_W-1:0] <= cur[OFS_W-1:0] + 1'b1;
        end else if (inc_full) begin
            cur <= cur + 1'b1;
        end
    end
endmodule

// File: rtl/pgc_page_buf.sv
module pgc_page_buf #(
    parameter int SLOTS  = 32,
    parameter int DATA_W = 8,
    localparam int OFS_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFS_W-1:0]  rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  mask_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_slot] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q[wr_slot] <= 1'b1;
        end
    end

    assign rd_data   = slot_q[rd_slot];
    assign rd_valid  = mask_q[rd_slot];
    assign any_valid = |mask_q;
endmodule

// File: rtl/pgc_commit_fsm.sv
module pgc_commit_fsm
    import pgc_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int WR_CYCLES = 1250000,
    localparam int OFS_W    = $clog2(SLOTS),
    localparam int CYC_W    = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             wp,
    output logic             busy,
    output logic             prog_active,
    output logic             prog_last,
    output logic [OFS_W-1:0] slot_idx,
    output logic             wp_lat
);
    pgc_state_t state, state_nxt;
    logic [CYC_W-1:0] timer;
    logic             timer_done;

    assign timer_done = (timer == CYC_W'(WR_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
            timer    <= '0;
            wp_lat   <= 1'b0;
        end else begin
            slot_idx <= (state == ST_PROGRAM) ? slot_idx + 1'b1 : '0;
            timer    <= (state == ST_SETTLE) ? timer + 1'b1 : '0;
            if (state == ST_COLLECT && go) begin
                wp_lat <= wp;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COLLECT: if (go)         state_nxt = ST_PROGRAM;
            ST_PROGRAM: if (prog_last)  state_nxt = ST_SETTLE;
            ST_SETTLE:  if (timer_done) state_nxt = ST_COLLECT;
            default:                    state_nxt = ST_COLLECT;
        endcase
    end

    always_comb begin
        busy        = (state != ST_COLLECT);
        prog_active = (state == ST_PROGRAM);
        prog_last   = prog_active && (slot_idx == OFS_W'(SLOTS - 1));
    end
endmodule

// File: rtl/page_commit.sv
module page_commit #(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              stop,
    input  logic              wp,
    input  logic              rd_inc,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic             accept, stop_ok, load_ok, byte_ok, rinc_ok;
    logic             pend_any, slot_valid, prog_active, prog_last, wp_lat;
    logic             top_quarter;
    logic [OFS_W-1:0] slot_idx;

    assign accept  = !busy;
    assign stop_ok = accept && stop;
    assign load_ok = accept && !stop && addr_load;
    assign byte_ok = accept && !stop && !addr_load && byte_stb;
    assign rinc_ok = accept && !stop && !addr_load && !byte_stb && rd_inc;

    pgc_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (addr_in),
        .inc_slot (byte_ok),
        .inc_full (rinc_ok),
        .cur      (cur_addr)
    );

    pgc_page_buf #(.SLOTS(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (byte_ok),
        .wr_slot   (cur_addr[OFS_W-1:0]),
        .wr_data   (byte_data),
        .clr       (load_ok || prog_last),
        .rd_slot   (slot_idx),
        .rd_data   (mem_wdata),
        .rd_valid  (slot_valid),
        .any_valid (pend_any)
    );

    pgc_commit_fsm #(.SLOTS(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (stop_ok && pend_any),
        .wp          (wp),
        .busy        (busy),
        .prog_active (prog_active),
        .prog_last   (prog_last),
        .slot_idx    (slot_idx),
        .wp_lat      (wp_lat)
    );

    // The counter is frozen while busy, so its page field names the page being committed.
    assign top_quarter = (cur_addr[ADDR_W-1 -: 2] == 2'b11);
    assign mem_addr    = {cur_addr[ADDR_W-1:OFS_W], slot_idx};
    assign mem_we      = prog_active && slot_valid && !(wp_lat && top_quarter);
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 1250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              stop,
    input logic              byte_stb,
    input logic              addr_load,
    input logic              wp,
    input logic              mem_we,
    input logic              pend_any,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int unsigned BUSY_LEN = PAGE_BYTES + WR_CYCLES;

    logic        wp_cap;
    int unsigned run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_cap  <= 1'b0;
            run_cnt <= 0;
        end else begin
            if (stop && !busy) wp_cap <= wp;
            run_cnt <= busy ? run_cnt + 1 : 0;
        end
    end

    p_addr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr));

    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_wp_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp_cap) |-> (mem_addr[ADDR_W-1 -: 2] != 2'b11));

    p_empty_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !busy && !pend_any) |=> !busy);

    p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_cnt != 0) |-> (run_cnt == BUSY_LEN));

    p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !busy && !stop && !addr_load) |=>
        (cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W])));
endmodule

bind page_commit pgc_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
) u_pgc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .stop      (stop),
    .byte_stb  (byte_stb),
    .addr_load (addr_load),
    .wp        (wp),
    .mem_we    (mem_we),
    .pend_any  (pend_any),
    .cur_addr  (cur_addr),
    .mem_addr  (mem_addr)
);

// File: tb/test_page_commit.sv
module test_page_commit;
    localparam int WR = 20;
    localparam int BUSY_LEN = 32 + WR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        addr_load = 1'b0;
    logic [11:0] addr_in = '0;
    logic        stop = 1'b0;
    logic        wp = 1'b0;
    logic        rd_inc = 1'b0;
    logic        busy, mem_we;
    logic [11:0] cur_addr, mem_addr;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_data [32];
    bit          m_val  [32];
    logic [11:0] m_cur = '0;
    logic [19:0] expq [$];

    always #4 clk = ~clk;

    page_commit #(.WR_CYCLES(WR)) i_page_commit (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
        .addr_load(addr_load), .addr_in(addr_in), .stop(stop), .wp(wp),
        .rd_inc(rd_inc), .busy(busy), .cur_addr(cur_addr), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: every array write must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (expq.size() == 0) begin
                chk("R6 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
            end else begin
                logic [19:0] e;
                e = expq.pop_front();
                chk("R6 write addr/data", {12'h0, mem_addr, mem_wdata}, {12'h0, e});
            end
        end
    end

    task automatic t_load(input logic [11:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
        m_cur = a;
        for (int i = 0; i < 32; i++) m_val[i] = 1'b0;
    endtask

    task automatic t_byte(input logic [7:0] d);
        @(negedge clk); byte_stb = 1'b1; byte_data = d;
        @(negedge clk); byte_stb = 1'b0;
        m_data[m_cur[4:0]] = d;
        m_val[m_cur[4:0]]  = 1'b1;
        m_cur[4:0] = m_cur[4:0] + 5'd1;
    endtask

    task automatic t_rdinc();
        @(negedge clk); rd_inc = 1'b1;
        @(negedge clk); rd_inc = 1'b0;
        m_cur = m_cur + 12'd1;
    endtask

    // Driver: pushes the expected writes, issues the stop, measures busy.
    task automatic t_stop(input logic w, input bit poke);
        bit any = 1'b0;
        int n;
        for (int i = 0; i < 32; i++) begin
            if (m_val[i]) begin
                any = 1'b1;
                if (!(w && m_cur[11:10] == 2'b11))
                    expq.push_back({m_cur[11:5], 5'(i), m_data[i]});
            end
        end
        @(negedge clk); stop = 1'b1; wp = w;
        @(negedge clk); stop = 1'b0;
        if (any) begin
            chk("R5 busy after stop", {31'h0, busy}, 32'h1);
            n = 1;
            while (busy) begin
                if (poke) begin
                    byte_stb  = (n == 1);
                    addr_load = (n == 2);
                    addr_in   = 12'h7FF;
                    rd_inc    = (n == 3);
                    stop      = (n == 4);
                    byte_data = 8'hEE;
                end
                @(negedge clk);
                if (busy) n++;
            end
            byte_stb = 1'b0; addr_load = 1'b0; rd_inc = 1'b0; stop = 1'b0;
            chk("R5 busy length", n, BUSY_LEN);
            chk("R6/R7 all expected writes seen", expq.size(), 0);
            if (poke) chk("R9 cur_addr unchanged while busy", {20'h0, cur_addr}, {20'h0, m_cur});
            @(negedge clk);
            chk("R9 no commit from stop while busy", {31'h0, busy}, 32'h0);
        end else begin
            for (int k = 0; k < 5; k++) begin
                chk("R8 no busy on empty stop", {31'h0, busy}, 32'h0);
                @(negedge clk);
            end
        end
        for (int i = 0; i < 32; i++) m_val[i] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cur_addr", {20'h0, cur_addr}, 32'h0);
        chk("R1 reset busy", {31'h0, busy}, 32'h0);
        chk("R1 reset mem_we", {31'h0, mem_we}, 32'h0);

        t_load(12'h123);
        chk("R2 address load", {20'h0, cur_addr}, {20'h0, m_cur});
        for (int i = 0; i < 3; i++) t_rdinc();
        chk("R4 read increments", {20'h0, cur_addr}, 32'h126);
        t_load(12'hFFF);
        t_rdinc();
        chk("R4 read wrap FFF to 000", {20'h0, cur_addr}, 32'h000);
        t_load(12'h03F);
        t_rdinc();
        chk("R4 read crosses page", {20'h0, cur_addr}, 32'h040);

        // Page wrap write: slots 30, 31, 0, 1 of page 2, with bus pokes while busy.
        t_load(12'h05E);
        t_byte(8'hA1); t_byte(8'hA2); t_byte(8'hA3); t_byte(8'hA4);
        chk("R3 page wrap counter", {20'h0, cur_addr}, 32'h042);
        t_stop(1'b0, 1'b1);

        // Empty transaction.
        t_load(12'h200);
        t_stop(1'b0, 1'b0);

        // Protected top quarter.
        t_load(12'hC20);
        t_byte(8'h11); t_byte(8'h22);
        t_stop(1'b1, 1'b0);
        // Protection on, lower page still written.
        t_load(12'h300);
        t_byte(8'h33); t_byte(8'h44);
        t_stop(1'b1, 1'b0);
        // Protection off, top quarter written.
        t_load(12'hFE0);
        t_byte(8'h55);
        t_stop(1'b0, 1'b0);

        // Overflow: 34 bytes into page 8.
        t_load(12'h100);
        for (int i = 0; i < 34; i++) t_byte(8'h40 + 8'(i));
        chk("R10 counter after 34 bytes", {20'h0, cur_addr}, 32'h102);
        t_stop(1'b0, 1'b0);

        // Reload discards pending bytes.
        t_load(12'h080);
        t_byte(8'h99);
        t_load(12'h0A0);
        t_byte(8'h77);
        chk("R2 reload counter", {20'h0, cur_addr}, 32'h0A1);
        t_stop(1'b0, 1'b0);

        repeat (3) @(negedge clk);
        chk("R6 queue drained at end", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule